// File: doc/BRIEF.md
# Serial-Load Latched Output Driver

This block is the digital core of a 32-output serial display driver. A host controller drives three wires: a serial data bit, a shift clock and a load-window signal. While the load window is high, each rising edge of the shift clock moves one bit into a 32-bit shift register. When the window closes (high to low), the register is copied into an output latch that drives the 32 parallel outputs. A bit value of 1 turns its output on.

The host wires are asynchronous to the on-chip clock. Each one passes through a two-flop synchroniser, and its edges are found in the system clock domain. A blanking input turns every output off without touching the latched pattern. A serial output presents the oldest register stage and moves on the falling edge of the shift clock, so several drivers can be chained. To clear the outputs, the host shifts 32 zeros inside one window and then closes the window.

Top module: `serial_latch_driver`

## Requirements
- R1: After an asynchronous reset (rst_ni low), all 32 outputs and the serial output are 0.
- R2: Bit order: the first bit shifted after the window opens drives out_o[0] after 32 shifts and the window closing. The last bit drives out_o[31], so out_o[k] equals shifted bit number k, counting from 0.
- R3: Shift-clock edges while the window is low change neither the register, the outputs nor the serial output. Closing a later empty window (no clocks inside it) therefore shows the earlier pattern again.
- R4: While a transfer is in progress the outputs keep showing the previously latched pattern.
- R5: Closing the window copies the register into the output latch. The new pattern appears on out_o three system clocks after the window fall is sampled.
- R6: While blank_i is 1, all outputs are 0. The latched pattern is kept and reappears when blank_i returns to 0.
- R7: On each falling edge of the shift clock inside the window, the serial output takes the oldest register stage. After 32 shifts it presents bit 0 of that transfer, and further shifts present bits 1, 2, … in order for a downstream device.
- R8: Shifting 32 zeros in one window and then closing it sets every output to 0.
- R9: Blanking is independent of the window and of the shift clock. If blank is held through a whole transfer, the outputs stay 0, and the new pattern shows once blank is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, faster than the shift clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Host shift clock |
| sdat_i | input | 1 | Host serial data |
| load_en_i | input | 1 | Load window; its falling edge latches the register |
| blank_i | input | 1 | 1 forces all outputs off |
| out_o | output | 32 | Parallel outputs, 1 = on |
| sdo_o | output | 1 | Serial cascade output |

## Verification
Each host wire reaches the logic after two synchroniser flops, and one more flop is used for edge detection. As a result:
- A shift, a latch transfer and a serial-output update land on the third system clock edge after the host edge is sampled.
- Blank reaches the outputs after two edges.

The bench drives each host wire on a falling system clock edge. It then waits four full system clocks before the next wire change or before sampling, so every result has settled. Every sample is taken on a falling edge, away from the edge that updates the registers.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int unsigned NUM_OUT     = 32;
  localparam int unsigned SYNC_DEPTH  = 2;

  typedef struct packed {
    logic sclk;
    logic sdat;
    logic en;
    logic blank;
  } sld_in_t;

  localparam int unsigned IN_W = $bits(sld_in_t);
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sld_edge.sv
module sld_edge
  import sld_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  sld_in_t sy_i,
  output logic    sclk_rise_o,
  output logic    sclk_fall_o,
  output logic    en_fall_o
);
  logic sclk_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      sclk_q <= sy_i.sclk;
      en_q   <= sy_i.en;
    end
  end

  assign sclk_rise_o = sy_i.sclk & ~sclk_q;
  assign sclk_fall_o = ~sy_i.sclk & sclk_q;
  assign en_fall_o   = en_q & ~sy_i.en;
endmodule

// File: rtl/sld_shift.sv
module sld_shift #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         din_i,
  output logic [N-1:0] shreg_o,
  output logic         sdo_o
);
  logic [N-1:0] shreg_q;
  logic         sdo_q;

  // new bits enter at the top; the oldest bit sits at index 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              shreg_q <= '0;
    else if (en_i && rise_i)  shreg_q <= {din_i, shreg_q[N-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              sdo_q <= 1'b0;
    else if (en_i && fall_i)  sdo_q <= shreg_q[0];
  end

  assign shreg_o = shreg_q;
  assign sdo_o   = sdo_q;
endmodule

// File: rtl/sld_latch.sv
module sld_latch #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         blank_i,
  input  logic [N-1:0] shreg_i,
  output logic [N-1:0] latch_o,
  output logic [N-1:0] out_o
);
  logic [N-1:0] latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     latch_q <= '0;
    else if (load_i) latch_q <= shreg_i;
  end

  assign latch_o = latch_q;
  assign out_o   = blank_i ? '0 : latch_q;
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
  import sld_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sdat_i,
  input  logic               load_en_i,
  input  logic               blank_i,
  output logic [NUM_OUT-1:0] out_o,
  output logic               sdo_o
);
  sld_in_t              raw_in, sy_in;
  logic [IN_W-1:0]      sy_bits;
  logic                 sclk_rise, sclk_fall, en_fall;
  logic [NUM_OUT-1:0]   shreg, latch_q;

  assign raw_in = '{sclk: sclk_i, sdat: sdat_i, en: load_en_i, blank: blank_i};

  sld_sync #(.WIDTH(IN_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (sy_bits)
  );
  assign sy_in = sld_in_t'(sy_bits);

  sld_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sy_i        (sy_in),
    .sclk_rise_o (sclk_rise),
    .sclk_fall_o (sclk_fall),
    .en_fall_o   (en_fall)
  );

  sld_shift #(.N(NUM_OUT)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (sy_in.en),
    .rise_i  (sclk_rise),
    .fall_i  (sclk_fall),
    .din_i   (sy_in.sdat),
    .shreg_o (shreg),
    .sdo_o   (sdo_o)
  );

  sld_latch #(.N(NUM_OUT)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (en_fall),
    .blank_i (sy_in.blank),
    .shreg_i (shreg),
    .latch_o (latch_q),
    .out_o   (out_o)
  );
endmodule

// File: rtl/sld_checker.sv
module sld_checker
  import sld_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               blank_i,
  input logic               en_lvl,
  input logic               sclk_fall,
  input logic               en_fall,
  input logic [NUM_OUT-1:0] shreg,
  input logic [NUM_OUT-1:0] latch_q,
  input logic [NUM_OUT-1:0] out_o,
  input logic               sdo_o
);
  p_blank_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(blank_i, 2) |-> out_o == '0);

  p_ignore_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_lvl |=> $stable(shreg));

  p_hold_during_xfer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_lvl |=> $stable(latch_q));

  p_latch_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_fall |=> latch_q == $past(shreg));

  p_sdo_oldest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_fall && en_lvl) |=> sdo_o == $past(shreg[0]));
endmodule

bind serial_latch_driver sld_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .blank_i   (blank_i),
  .en_lvl    (sy_in.en),
  .sclk_fall (sclk_fall),
  .en_fall   (en_fall),
  .shreg     (shreg),
  .latch_q   (latch_q),
  .out_o     (out_o),
  .sdo_o     (sdo_o)
);

// File: tb/serial_latch_driver_tb.sv
module serial_latch_driver_tb;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sclk_i = 1'b0, sdat_i = 1'b0, load_en_i = 1'b0, blank_i = 1'b0;
  logic [N-1:0] out_o;
  logic         sdo_o;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [N-1:0] m_sr = '0, m_latch = '0;
  logic         m_sdo = 1'b0;

  always #4 clk = ~clk;

  serial_latch_driver u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdat_i(sdat_i),
    .load_en_i(load_en_i), .blank_i(blank_i), .out_o(out_o), .sdo_o(sdo_o)
  );

  function automatic logic [N-1:0] shift_in(logic [N-1:0] sr, logic d);
    return {d, sr[N-1:1]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // one shift-clock pulse; model follows R2/R3/R7
  task automatic pulse(input logic d, input bit check_sdo);
    @(negedge clk); sdat_i = d;
    settle();
    sclk_i = 1'b1;
    settle();
    if (load_en_i) m_sr = shift_in(m_sr, d);
    sclk_i = 1'b0;
    settle();
    if (load_en_i) m_sdo = m_sr[0];
    if (check_sdo) chk(sdo_o == m_sdo, "R7 sdo", {31'b0, sdo_o}, {31'b0, m_sdo});
  endtask

  task automatic set_en(input logic v);
    @(negedge clk); load_en_i = v;
    settle();
    if (!v) m_latch = m_sr;
  endtask

  task automatic load(input logic [N-1:0] pat, input bit check_hold);
    set_en(1'b1);
    for (int i = 0; i < N; i++) begin
      pulse(pat[i], 1'b1);
      if (check_hold && (i == N/2 || i == N-1))
        chk(out_o == (blank_i ? '0 : m_latch), "R4 hold during transfer", out_o, m_latch);
    end
    set_en(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat, prev;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    settle();
    chk(out_o == '0, "R1 outputs after reset", out_o, '0);
    chk(sdo_o == 1'b0, "R1 sdo after reset", {31'b0, sdo_o}, '0);

    // random loads: order, hold, latch, cascade
    for (int k = 0; k < 4; k++) begin
      pat = $urandom();
      load(pat, 1'b1);
      chk(out_o == pat, "R5 latched pattern", out_o, pat);
      chk(out_o[0] == pat[0] && out_o[N-1] == pat[N-1], "R2 bit order", out_o, pat);
    end

    // directed: single first bit, all ones
    load(32'h0000_0001, 1'b1);
    chk(out_o == 32'h0000_0001, "R2 first bit to out_o[0]", out_o, 32'h1);
    load('1, 1'b1);
    chk(out_o == '1, "R5 all ones", out_o, '1);

    // R3: clocks with window low are ignored
    prev = out_o;
    for (int i = 0; i < 6; i++) pulse(1'b0, 1'b1);
    chk(out_o == prev, "R3 outputs unchanged by idle clocks", out_o, prev);
    set_en(1'b1);
    set_en(1'b0);
    chk(out_o == prev, "R3 register unchanged by idle clocks", out_o, prev);

    // R6: blank override keeps data
    @(negedge clk); blank_i = 1'b1;
    settle();
    chk(out_o == '0, "R6 blank forces off", out_o, '0);
    @(negedge clk); blank_i = 1'b0;
    settle();
    chk(out_o == m_latch, "R6 pattern returns", out_o, m_latch);

    // R9: blank held across a whole transfer
    @(negedge clk); blank_i = 1'b1;
    pat = $urandom();
    load(pat, 1'b1);
    chk(out_o == '0, "R9 blank during transfer", out_o, '0);
    @(negedge clk); blank_i = 1'b0;
    settle();
    chk(out_o == pat, "R9 new pattern after unblank", out_o, pat);

    // R7: explicit cascade order of previous pattern
    set_en(1'b1);
    for (int i = 0; i < 8; i++) begin
      pulse(1'b0, 1'b0);
      chk(sdo_o == pat[i+1], "R7 cascade order", {31'b0, sdo_o}, {31'b0, pat[i+1]});
    end
    for (int i = 8; i < N; i++) pulse(1'b1, 1'b0);
    set_en(1'b0);

    // R8: clear sequence
    load('0, 1'b0);
    chk(out_o == '0, "R8 clear sequence", out_o, '0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule